// File: doc/BRIEF.md
# AHB Burst Slave Bridge

This block is the slave-side front end of an AHB-Lite segment. It converts the pipelined address and data phases of AHB into two decoupled channels. A request channel carries one descriptor for each burst: start address, direction, transfer size, and beat count. A data channel carries one entry for each beat: the beat address, the write data, a strobe that marks a real beat, and a flush marker that tells downstream logic the burst has closed early. A request is issued as soon as the first beat is accepted. It does not wait for that beat's data phase.

The bridge reads HBURST when it accepts the NONSEQ beat and uses it to learn the expected beat count. While it expects SEQ, an IDLE or NONSEQ on HTRANS means the master has abandoned the burst. Incrementing bursts of undefined length always end this way. The block raises flush on the final real beat. If the master abandons the burst right after a BUSY cycle, no real beat is left to carry the flush. In that case the bridge stalls HREADY for one cycle and emits a dummy beat with the strobe low and flush high. It also computes the address of each beat itself, wrapping where the burst type requires it. HREADY falls whenever either downstream channel cannot take what the bridge holds. The block drives HREADY itself and assumes it is the only slave on its segment.

Top module: `ahb_burst_bridge`

## Requirements
- R1: When a NONSEQ is accepted, one request is issued. It carries haddr, hwrite and hsize, and a length taken from hburst: 0 gives 1, 1 gives length 0 with req_open=1, 2 or 3 gives 4, 4 or 5 gives 8, and 6 or 7 gives 16. req_open is 0 for every hburst value other than 1.
- R2: A fixed-length burst that runs to its full beat count yields exactly that many data beats, all with dat_strb=1 and dat_flush=0. After the last beat, an IDLE or NONSEQ is not treated as an abort.
- R3: Beat i (counting from 0) of a burst with start address A and size s has dat_addr = A + i*2^s. For wrapping bursts (hburst 2, 4 or 6), the address wraps inside the block of len*2^s bytes aligned to that size that holds A.
- R4: While a SEQ is expected, an IDLE or NONSEQ that follows a real beat closes the burst. That last real beat carries dat_strb=1 and dat_flush=1.
- R5: If the closing IDLE or NONSEQ follows a BUSY cycle, the bridge holds hready low and emits one extra beat with dat_strb=0 and dat_flush=1. After that it accepts the pending transfer.
- R6: A BUSY cycle inside a burst produces no data beat and no flush. The burst then continues on the next SEQ.
- R7: An undefined-length incrementing burst yields one beat for each accepted beat. Its request has req_len=0 and req_open=1, and its final beat or dummy beat carries dat_flush=1.
- R8: A NONSEQ that aborts a burst starts a new request. That request completes its handshake strictly after the flush beat of the aborted burst.
- R9: hready is low while a request is held with req_ready low, or while a beat is held with dat_ready low. A held request or beat stays valid and unchanged, and every beat is delivered exactly once.
- R10: dat_wdata carries the hwdata of each beat's data phase, and hrdata follows dat_rdata.
- R11: After reset, req_valid and dat_valid are 0 and hready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hburst | input | 3 | Burst type |
| hsize | input | 3 | Transfer size, log2 of bytes |
| hwrite | input | 1 | 1 for a write |
| haddr | input | AW | Transfer address |
| hwdata | input | DW | Write data of the current data phase |
| hrdata | output | DW | Read data |
| hready | output | 1 | Transfer done / slave ready |
| req_valid | output | 1 | Request descriptor valid |
| req_ready | input | 1 | Request accepted by downstream |
| req_addr | output | AW | Burst start address |
| req_write | output | 1 | Burst direction |
| req_size | output | 3 | Burst transfer size |
| req_len | output | 5 | Beat count, 0 when open |
| req_open | output | 1 | Length not known, closed by flush |
| dat_valid | output | 1 | Data beat valid |
| dat_ready | input | 1 | Data beat accepted by downstream |
| dat_addr | output | AW | Beat address |
| dat_write | output | 1 | Beat direction |
| dat_wdata | output | DW | Beat write data |
| dat_rdata | input | DW | Beat read data from downstream |
| dat_strb | output | 1 | Real beat (0 on a dummy flush beat) |
| dat_flush | output | 1 | Burst closed early |

## Verification
The bench builds the bridge with AW=16 and DW=32. It sweeps every hburst code, sizes 0 to 2, every abort position from the first beat up to full length, an optional BUSY before the abort or in the middle of a full burst, and a closing IDLE or NONSEQ. Both ready inputs toggle pseudo-randomly throughout, so every stall path is exercised with every burst shape. At 16-bit addresses, wrap blocks of up to 64 bytes are crossed from start offsets inside the block, so every wrap point is reached.

// File: rtl/ahb_burst_bridge.sv
module ahb_burst_bridge #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic [2:0]    hburst,
  input  logic [2:0]    hsize,
  input  logic          hwrite,
  input  logic [AW-1:0] haddr,
  input  logic [DW-1:0] hwdata,
  output logic [DW-1:0] hrdata,
  output logic          hready,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_write,
  output logic [2:0]    req_size,
  output logic [4:0]    req_len,
  output logic          req_open,
  output logic          dat_valid,
  input  logic          dat_ready,
  output logic [AW-1:0] dat_addr,
  output logic          dat_write,
  output logic [DW-1:0] dat_wdata,
  input  logic [DW-1:0] dat_rdata,
  output logic          dat_strb,
  output logic          dat_flush
);
  localparam logic [1:0] T_IDLE = 2'd0, T_BUSY = 2'd1, T_NSEQ = 2'd2, T_SEQ = 2'd3;

  typedef enum logic {ST_IDLE, ST_BURST} state_t;

  state_t        st;
  logic [4:0]    rem, len_r;
  logic          open_r, wrap_r, dph_v, dph_wr;
  logic [2:0]    size_r;
  logic [AW-1:0] cur_addr;

  logic [1:0]    tr;
  logic          abort, dummy, req_ok;
  logic [4:0]    new_len;
  logic [AW-1:0] step, sum, mask, nxt_addr;

  assign tr      = hsel ? htrans : T_IDLE;
  assign abort   = (st == ST_BURST) && (tr == T_IDLE || tr == T_NSEQ);
  assign dummy   = abort && !dph_v;
  assign req_ok  = !req_valid || req_ready;
  assign hready  = req_ok && !dummy && (!dph_v || dat_ready);

  assign dat_valid = req_ok && (dph_v || dummy);
  assign dat_strb  = dph_v;
  assign dat_flush = dat_valid && abort;
  assign dat_addr  = cur_addr;
  assign dat_write = dph_wr;
  assign dat_wdata = hwdata;
  assign hrdata    = dat_rdata;

  assign new_len  = (hburst == 3'd0) ? 5'd1 : (hburst == 3'd1) ? 5'd0 : 5'd2 << hburst[2:1];
  assign step     = AW'(1) << size_r;
  assign sum      = cur_addr + step;
  assign mask     = (AW'(len_r) << size_r) - AW'(1);
  assign nxt_addr = wrap_r ? ((cur_addr & ~mask) | (sum & mask)) : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rem <= '0; len_r <= '0; open_r <= 1'b0; wrap_r <= 1'b0;
      size_r <= '0; cur_addr <= '0; dph_v <= 1'b0; dph_wr <= 1'b0;
    end else if (dummy && dat_valid && dat_ready) begin
      st <= ST_IDLE;
    end else if (hready) begin
      dph_v <= (tr == T_NSEQ) || (tr == T_SEQ && st == ST_BURST);
      if (tr == T_NSEQ) begin
        cur_addr <= haddr;
        size_r   <= hsize;
        len_r    <= new_len;
        open_r   <= (hburst == 3'd1);
        wrap_r   <= (hburst != 3'd0) && !hburst[0];
        rem      <= new_len - 5'd1;
        dph_wr   <= hwrite;
        st       <= (hburst == 3'd0) ? ST_IDLE : ST_BURST;
      end else begin
        case (st)
          ST_IDLE: st <= ST_IDLE;
          ST_BURST: begin
            case (tr)
              T_SEQ: begin
                cur_addr <= nxt_addr;
                if (!open_r) begin
                  rem <= rem - 5'd1;
                  if (rem == 5'd1) st <= ST_IDLE;
                end
              end
              T_BUSY:  st <= ST_BURST;
              default: st <= ST_IDLE;
            endcase
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0; req_addr <= '0; req_write <= 1'b0;
      req_size <= '0; req_len <= '0; req_open <= 1'b0;
    end else begin
      if (req_ready) req_valid <= 1'b0;
      if (hready && tr == T_NSEQ) begin
        req_valid <= 1'b1;
        req_addr  <= haddr;
        req_write <= hwrite;
        req_size  <= hsize;
        req_len   <= new_len;
        req_open  <= (hburst == 3'd1);
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)); // R9
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && !dat_ready |=> dat_valid && $stable(dat_addr) && $stable(dat_flush)); // R9
  AST_DUMMY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && !dat_strb |-> !hready && dat_flush); // R5
  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BURST && !open_r |-> rem != 5'd0); // R2
endmodule

// File: tb/ahb_burst_bridge_tb_top.sv
`timescale 1ns/1ps
module ahb_burst_bridge_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsel = 1'b0, hwrite = 1'b0;
  logic [1:0] htrans = 2'd0;
  logic [2:0] hburst = 3'd0, hsize = 3'd0;
  logic [15:0] haddr = '0;
  logic [31:0] hwdata = '0, hrdata, dat_rdata = 32'h1234_5678;
  logic hready, req_valid, req_ready, req_write, req_open;
  logic [15:0] req_addr, dat_addr;
  logic [2:0] req_size;
  logic [4:0] req_len;
  logic dat_valid, dat_ready, dat_write, dat_strb, dat_flush;
  logic [31:0] dat_wdata;

  ahb_burst_bridge #(.AW(16), .DW(32)) dut_i (.*);

  always #2 clk = ~clk;

  int nvec = 0, nbad = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit force_rdy = 1'b1;
  always @(negedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready <= force_rdy | lfsr[3];
    dat_ready <= force_rdy | lfsr[7];
  end

  logic [15:0] m_da[64]; logic m_ds[64], m_df[64]; logic [31:0] m_dw[64]; int m_dt[64];
  logic [15:0] m_ra[8]; logic m_rw[8], m_ro[8]; logic [4:0] m_rl[8]; logic [2:0] m_rs[8]; int m_rt[8];
  int nd = 0, nr = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n && dat_valid && dat_ready && nd < 64) begin
      m_da[nd] = dat_addr; m_ds[nd] = dat_strb; m_df[nd] = dat_flush; m_dw[nd] = dat_wdata; m_dt[nd] = cyc; nd++;
    end
    if (rst_n && req_valid && req_ready && nr < 8) begin
      m_ra[nr] = req_addr; m_rw[nr] = req_write; m_ro[nr] = req_open; m_rl[nr] = req_len;
      m_rs[nr] = req_size; m_rt[nr] = cyc; nr++;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s got %h exp %h", r, got, exp);
    end
  endtask

  logic [31:0] dval = '0;
  task automatic aphase(input logic [1:0] t, input logic [15:0] a, input logic [2:0] b, input logic [2:0] s,
                        input logic w, input logic [31:0] v);
    bit rdy;
    do begin
      @(negedge clk);
      hsel = 1'b1; htrans = t; haddr = a; hburst = b; hsize = s; hwrite = w; hwdata = dval;
      #1 rdy = hready;
      @(posedge clk);
    end while (!rdy);
    if (t == 2'd2 || t == 2'd3) dval = v;
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] a0, input int i, input int s, input int len, input bit wrp);
    logic [15:0] m, sm;
    sm = a0 + 16'(i << s);
    m  = 16'((len << s) - 1);
    return wrp ? ((a0 & ~m) | (sm & m)) : sm;
  endfunction

  task automatic run(input int b, input int s, input int k, input bit busy, input bit term_ns, input bit w);
    int len; bit open, wrp, aborted; logic [15:0] a0, ea; int ndexp, di; logic [4:0] elen;
    open = (b == 1); wrp = (b >= 2) && (b % 2 == 0);
    len  = (b == 0) ? 1 : (b == 1) ? 0 : (2 << (b >> 1));
    elen = 5'(len);
    aborted = open || (k < len);
    a0 = 16'h0200 + 16'((((k * 3) % ((len == 0) ? 4 : len))) << s);
    nd = 0; nr = 0;
    force_rdy = 1'b0;
    aphase(2'd2, a0, 3'(b), 3'(s), w, 32'hC0DE_0000);
    for (int i = 1; i < k; i++) begin
      ea = exp_addr(a0, i, s, len, wrp);
      if (busy && !aborted && i == 1) aphase(2'd1, ea, 3'(b), 3'(s), w, 0);
      aphase(2'd3, ea, 3'(b), 3'(s), w, 32'hC0DE_0000 | i);
    end
    if (busy && aborted) aphase(2'd1, 16'h0, 3'(b), 3'(s), w, 0);
    if (term_ns) aphase(2'd2, 16'h8000, 3'd0, 3'(s), w, 32'hBEEF_0000);
    aphase(2'd0, 16'h0, 3'd0, 3'd0, 1'b0, 0);
    force_rdy = 1'b1;
    repeat (4) aphase(2'd0, 16'h0, 3'd0, 3'd0, 1'b0, 0);
    hsel = 1'b0;

    chk(nr == 1 + int'(term_ns), "R1 request count", nr, 1 + int'(term_ns));
    chk(m_ra[0] == a0 && m_rw[0] == w && m_rs[0] == 3'(s), "R1 request fields", m_ra[0], a0);
    chk(m_rl[0] == elen && m_ro[0] == open, open ? "R7 open request" : "R1 request length",
        {m_ro[0], m_rl[0]}, {open, elen});
    ndexp = k + int'(aborted && busy) + int'(term_ns);
    chk(nd == ndexp, "R9 beat count", nd, ndexp);
    if (nd == ndexp) begin
      for (int i = 0; i < k; i++) begin
        ea = exp_addr(a0, i, s, len, wrp);
        chk(m_da[i] == ea, wrp ? "R3 wrapped beat address" : "R3 beat address", m_da[i], ea);
        chk(m_ds[i] == 1'b1, "R2 beat strobe", m_ds[i], 1);
        if (aborted && !busy && i == k - 1)
          chk(m_df[i] == 1'b1, open ? "R7 flush on last beat" : "R4 flush on last beat", m_df[i], 1);
        else
          chk(m_df[i] == 1'b0, busy ? "R6 no flush around BUSY" : "R2 no flush", m_df[i], 0);
        if (w) chk(m_dw[i] == (32'hC0DE_0000 | i), "R10 write data", m_dw[i], 32'hC0DE_0000 | i);
      end
      di = k;
      if (aborted && busy) begin
        chk(m_ds[di] == 1'b0 && m_df[di] == 1'b1, "R5 dummy flush beat", {m_ds[di], m_df[di]}, 2'b01);
        di++;
      end
      if (term_ns) begin
        chk(m_da[di] == 16'h8000 && m_ds[di] && !m_df[di], "R8 new burst beat", m_da[di], 16'h8000);
        chk(m_ra[1] == 16'h8000 && m_rl[1] == 5'd1, "R8 new request", m_ra[1], 16'h8000);
        if (aborted)
          chk(m_rt[1] > m_dt[di - 1], "R8 request after flush beat", m_rt[1], m_dt[di - 1]);
      end
    end
  endtask

  initial begin
    #600000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int cnt = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid && !dat_valid && hready, "R11 reset state", {req_valid, dat_valid, hready}, 3'b001);
    chk(hrdata == 32'h1234_5678, "R10 read data path", hrdata, 32'h1234_5678);
    rst_n = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 8; b++) begin
        int len;
        len = (b == 0) ? 1 : (b == 1) ? 5 : (2 << (b >> 1));
        for (int k = 1; k <= len; k++)
          for (int bz = 0; bz < 2; bz++)
            for (int tn = 0; tn < 2; tn++) begin
              run(b, s, k, bit'(bz), bit'(tn), bit'(cnt % 2));
              cnt++;
            end
      end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule